// File: doc/BRIEF.md
# Two-Stage Overflow Watchdog Timer

This block is a watchdog peripheral with two clock domains. Software reaches it through a register port clocked by the peripheral clock. The timing counter runs on a separate oscillator clock. Software loads a 12-bit period setting, sets the enable bit, and must then service the watchdog from time to time.

One overflow window lasts 2^PRE_W × (setting + 1) oscillator cycles, where PRE_W is 20 by default. When the first window expires with no service, the interrupt output rises. If a second window then expires with still no service, the reset-request output rises. It stays high until the block is reset. Servicing restarts the window and removes the pending interrupt.

Writes to the control, period and counter registers reach the oscillator domain through a toggle handshake. Each such write therefore takes effect a few oscillator cycles after the bus write. A service write crosses by the same path. The elapsed-window count is sent back so that software can read it.

Top module: `wdt_dual_overflow`

## Requirements
- R1: After reset, irq and rst_req are 0, and the registers at byte offsets 0x0, 0x4, 0x8 and 0xC all read 0.
- R2: Bit 0 of the control register (offset 0x0) is the enable bit. It reads back as written, and bits 31:1 always read 0.
- R3: The period setting sits in bits 31:20 of offset 0x4. Writes to bits 19:0 are ignored, and those bits read 0.
- R4: An enabling write makes irq rise between P and P+6 oscillator cycles after the write, with P = 2^PRE_W × (setting + 1). Once high, irq stays high with no service.
- R5: If a second window expires while irq is pending, rst_req rises exactly P oscillator cycles after irq rose. After that, rst_req and irq both stay high until reset, even if a service write arrives.
- R6: Writing offset 0xC with bit 0 = 1 clears irq and restarts the window, so irq next rises between P and P+6 cycles after that write. Writing 0xC with bit 0 = 0 has no effect. Bit 0 of a read of 0xC shows the pending interrupt.
- R7: Writing all-zero data to offset 0x8 restarts the window without clearing irq. A nonzero write to 0x8 is ignored.
- R8: Bits 11:0 of offset 0x8 read the number of 2^PRE_W-cycle ticks elapsed in the current window, and bits 31:12 read 0.
- R9: While enable is 0, the prescaler and the window count are held at zero, and irq does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Peripheral (register) clock |
| osc_clk | input | 1 | Oscillator (counting) clock |
| rst | input | 1 | Synchronous active-high reset, seen by both domains |
| wr_en | input | 1 | One-cycle register write strobe |
| addr | input | 4 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 1 | First-overflow interrupt, held until serviced |
| rst_req | output | 1 | Second-overflow reset request, held until reset |

## Verification
The checker runs on every cycle and enforces the following:
- rst_req never drops and never appears without irq.
- A disabled counter keeps the window count at zero and never raises irq.
- The padding bits of the control and period registers read zero.

The directed scenarios cover what only measured timing can show:
- the window length for several settings, including the crossing latency;
- the exact one-period gap between irq and rst_req;
- the restart caused by a service write and by a zero write to the counter;
- the ignored nonzero and bit-0-clear writes;
- the tick count read back through the peripheral domain.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int SET_W   = 12;
    localparam int SET_LSB = DATA_W - SET_W;

    localparam logic [ADDR_W-1:0] OFF_CTRL    = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_PERIOD  = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_COUNT   = 4'h8;
    localparam logic [ADDR_W-1:0] OFF_SERVICE = 4'hC;

    typedef struct packed {
        logic             enable;
        logic [SET_W-1:0] setting;
    } wdt_cfg_t;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_WARN = 2'd1,
        ST_BITE = 2'd2
    } wdt_state_e;

    function automatic logic [DATA_W-1:0] place_setting(input logic [SET_W-1:0] s);
        return {s, {SET_LSB{1'b0}}};
    endfunction
endpackage

// File: rtl/wdt_sync_chain.sv
module wdt_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) ff <= '0;
                else     ff <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) ff <= '0;
                else     ff <= {ff[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = ff[STAGES-1];
endmodule

// File: rtl/wdt_sync_pulse.sv
module wdt_sync_pulse #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic dst_clk,
    input  logic rst,
    input  logic src_pulse,
    output logic dst_pulse
);
    logic tgl;
    logic tgl_s;
    logic tgl_d;

    always_ff @(posedge src_clk) begin
        if (rst)            tgl <= 1'b0;
        else if (src_pulse) tgl <= ~tgl;
    end

    wdt_sync_chain #(.STAGES(STAGES)) u_chain (
        .clk(dst_clk), .rst(rst), .d(tgl), .q(tgl_s)
    );

    always_ff @(posedge dst_clk) begin
        if (rst) tgl_d <= 1'b0;
        else     tgl_d <= tgl_s;
    end

    assign dst_pulse = tgl_s ^ tgl_d;
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
(
    input  logic              pclk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SET_W-1:0]  cnt_val,
    input  logic              cnt_upd,
    input  logic              irq_seen,
    output logic [DATA_W-1:0] rdata,
    output wdt_cfg_t          cfg,
    output logic              cfg_wr,
    output logic              init_wr,
    output logic              clr_wr
);
    logic [SET_W-1:0] cnt_q;

    always_ff @(posedge pclk) begin
        if (rst) begin
            cfg   <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_en && addr == OFF_CTRL)   cfg.enable  <= wdata[0];
            if (wr_en && addr == OFF_PERIOD) cfg.setting <= wdata[DATA_W-1 -: SET_W];
            if (cnt_upd)                     cnt_q       <= cnt_val;
        end
    end

    assign cfg_wr  = wr_en && (addr == OFF_CTRL || addr == OFF_PERIOD);
    assign init_wr = wr_en && (addr == OFF_COUNT) && (wdata == '0);
    assign clr_wr  = wr_en && (addr == OFF_SERVICE) && wdata[0];

    always_comb begin
        case (addr)
            OFF_CTRL:    rdata = {{(DATA_W-1){1'b0}}, cfg.enable};
            OFF_PERIOD:  rdata = place_setting(cfg.setting);
            OFF_COUNT:   rdata = {{(DATA_W-SET_W){1'b0}}, cnt_q};
            OFF_SERVICE: rdata = {{(DATA_W-1){1'b0}}, irq_seen};
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int PRE_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  wdt_cfg_t         cfg_in,
    input  logic             init_p,
    input  logic             clr_p,
    output wdt_cfg_t         cur_cfg,
    output logic [SET_W-1:0] lap,
    output logic             lap_chg,
    output logic             irq,
    output logic             rst_req
);
    wdt_cfg_t         cfg_q;
    logic [PRE_W-1:0] pre;
    logic [SET_W-1:0] lap_q;
    logic [SET_W-1:0] lap_d;
    wdt_state_e       st;
    logic             tick;
    logic             restart;
    logic             wrap;

    assign tick    = &pre;
    assign restart = clr_p || init_p;
    assign wrap    = cfg_q.enable && tick && (lap_q >= cfg_q.setting) && !restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            pre   <= '0;
            lap_q <= '0;
            lap_d <= '0;
            st    <= ST_RUN;
        end else begin
            lap_d <= lap_q;
            if (cfg_load) cfg_q <= cfg_in;

            if (!cfg_q.enable || restart) begin
                pre   <= '0;
                lap_q <= '0;
            end else begin
                pre <= pre + 1'b1;
                if (tick) lap_q <= (lap_q >= cfg_q.setting) ? '0 : lap_q + 1'b1;
            end

            if (clr_p && st == ST_WARN) begin
                st <= ST_RUN;
            end else if (wrap) begin
                case (st)
                    ST_RUN:  st <= ST_WARN;
                    ST_WARN: st <= ST_BITE;
                    default: st <= st;
                endcase
            end
        end
    end

    assign cur_cfg = cfg_q;
    assign lap     = lap_q;
    assign lap_chg = lap_q != lap_d;
    assign irq     = st != ST_RUN;
    assign rst_req = st == ST_BITE;
endmodule

// File: rtl/wdt_dual_overflow.sv
module wdt_dual_overflow
    import wdt_pkg::*;
#(
    parameter int PRE_W       = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic              pclk,
    input  logic              osc_clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              rst_req
);
    wdt_cfg_t         cfg;
    wdt_cfg_t         core_cfg;
    logic             cfg_wr, init_wr, clr_wr;
    logic             cfg_load, init_p, clr_p;
    logic [SET_W-1:0] core_lap;
    logic             lap_chg;
    logic             cnt_upd;
    logic             irq_p;

    wdt_regs u_regs (
        .pclk(pclk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cnt_val(core_lap), .cnt_upd(cnt_upd), .irq_seen(irq_p),
        .rdata(rdata), .cfg(cfg), .cfg_wr(cfg_wr), .init_wr(init_wr), .clr_wr(clr_wr)
    );

    wdt_sync_pulse #(.STAGES(SYNC_STAGES)) u_cfg_x (
        .src_clk(pclk), .dst_clk(osc_clk), .rst(rst), .src_pulse(cfg_wr), .dst_pulse(cfg_load)
    );
    wdt_sync_pulse #(.STAGES(SYNC_STAGES)) u_init_x (
        .src_clk(pclk), .dst_clk(osc_clk), .rst(rst), .src_pulse(init_wr), .dst_pulse(init_p)
    );
    wdt_sync_pulse #(.STAGES(SYNC_STAGES)) u_clr_x (
        .src_clk(pclk), .dst_clk(osc_clk), .rst(rst), .src_pulse(clr_wr), .dst_pulse(clr_p)
    );
    wdt_sync_pulse #(.STAGES(SYNC_STAGES)) u_cnt_x (
        .src_clk(osc_clk), .dst_clk(pclk), .rst(rst), .src_pulse(lap_chg), .dst_pulse(cnt_upd)
    );
    wdt_sync_chain #(.STAGES(SYNC_STAGES)) u_irq_x (
        .clk(pclk), .rst(rst), .d(irq), .q(irq_p)
    );

    wdt_core #(.PRE_W(PRE_W)) u_core (
        .clk(osc_clk), .rst(rst), .cfg_load(cfg_load), .cfg_in(cfg),
        .init_p(init_p), .clr_p(clr_p), .cur_cfg(core_cfg), .lap(core_lap),
        .lap_chg(lap_chg), .irq(irq), .rst_req(rst_req)
    );
endmodule

// File: rtl/wdt_dual_overflow_chk.sv
module wdt_dual_overflow_chk
    import wdt_pkg::*;
(
    input logic              pclk,
    input logic              osc_clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              irq,
    input logic              rst_req,
    input logic              enabled,
    input logic [SET_W-1:0]  lap
);
    assert_bite_sticky_R5: assert property (@(posedge osc_clk) disable iff (rst)
        rst_req |=> rst_req);

    assert_bite_needs_warn_R5: assert property (@(posedge osc_clk) disable iff (rst)
        $rose(rst_req) |-> $past(irq));

    assert_bite_keeps_irq_R5: assert property (@(posedge osc_clk) disable iff (rst)
        rst_req |-> irq);

    assert_idle_no_irq_R9: assert property (@(posedge osc_clk) disable iff (rst)
        !enabled |=> !$rose(irq));

    assert_idle_count_zero_R9: assert property (@(posedge osc_clk) disable iff (rst)
        !enabled |=> lap == '0);

    assert_period_pad_R3: assert property (@(posedge pclk) disable iff (rst)
        (addr == OFF_PERIOD) |-> rdata[SET_LSB-1:0] == '0);

    assert_ctrl_pad_R2: assert property (@(posedge pclk) disable iff (rst)
        (addr == OFF_CTRL) |-> rdata[DATA_W-1:1] == '0);
endmodule

bind wdt_dual_overflow wdt_dual_overflow_chk u_chk (
    .pclk(pclk), .osc_clk(osc_clk), .rst(rst), .addr(addr), .rdata(rdata),
    .irq(irq), .rst_req(rst_req), .enabled(core_cfg.enable), .lap(core_lap)
);

// File: tb/sim_wdt_dual_overflow.sv
`timescale 1ns/1ps
module sim_wdt_dual_overflow;
    localparam int PRE_W = 4;
    localparam int TICK  = 1 << PRE_W;
    localparam int SLACK = 6;

    logic        pclk = 0, osc_clk = 0, rst = 1, wr_en = 0;
    logic [3:0]  addr = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata;
    logic        irq, rst_req;
    int          total = 0, bad = 0;
    int          osc_cnt = 0;

    always #2.5 pclk = ~pclk;
    always #4   osc_clk = ~osc_clk;
    always @(posedge osc_clk) osc_cnt <= osc_cnt + 1;

    wdt_dual_overflow #(.PRE_W(PRE_W)) u0 (
        .pclk(pclk), .osc_clk(osc_clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge pclk); wr_en = 1; addr = a; wdata = d;
        @(negedge pclk); wr_en = 0; addr = 0; wdata = 0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge pclk); addr = a; #1; d = rdata;
        @(negedge pclk); addr = 0;
    endtask

    task automatic osc_wait(input int n);
        repeat (n) @(posedge osc_clk);
        #1;
    endtask

    task automatic wait_until(input int t);
        while (osc_cnt < t) @(posedge osc_clk);
        #1;
    endtask

    task automatic wait_irq(input int lim, output int t);
        int start = osc_cnt;
        while (irq !== 1'b1 && osc_cnt < start + lim) begin @(posedge osc_clk); #1; end
        t = osc_cnt;
    endtask

    task automatic wait_bite(input int lim, output int t);
        int start = osc_cnt;
        while (rst_req !== 1'b1 && osc_cnt < start + lim) begin @(posedge osc_clk); #1; end
        t = osc_cnt;
    endtask

    task automatic do_reset;
        rst = 1; wr_en = 0; addr = 0; wdata = 0;
        osc_wait(6);
        @(negedge pclk); rst = 0;
        osc_wait(2);
    endtask

    task automatic start_wdt(input int set, output int t0);
        bus_wr(4'h4, set << 20);
        bus_wr(4'h0, 32'h1);
        t0 = osc_cnt;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        do_reset();
        check(irq === 1'b0, "R1 irq after reset", irq, 0);
        check(rst_req === 1'b0, "R1 rst_req after reset", rst_req, 0);
        for (int i = 0; i < 4; i++) begin
            bus_rd(4'(i * 4), d);
            check(d == 0, "R1 register reads zero", d, 0);
        end
    endtask

    task automatic t_regs;
        logic [31:0] d;
        do_reset();
        bus_wr(4'h0, 32'hFFFF_FFFE);
        bus_rd(4'h0, d);
        check(d == 0, "R2 control upper bits read zero", d, 0);
        bus_wr(4'h0, 32'h0000_0001);
        bus_rd(4'h0, d);
        check(d == 1, "R2 enable bit reads back", d, 1);
        bus_wr(4'h0, 32'h0);
        bus_wr(4'h4, 32'hFFFF_FFFF);
        bus_rd(4'h4, d);
        check(d == 32'hFFF0_0000, "R3 period low bits masked", d, 32'hFFF0_0000);
        bus_wr(4'h4, 32'h002A_BCDE);
        bus_rd(4'h4, d);
        check(d == 32'h0020_0000, "R3 period field placement", d, 32'h0020_0000);
    endtask

    task automatic t_disabled;
        logic [31:0] d;
        do_reset();
        bus_wr(4'h4, 32'h0);
        bus_wr(4'h0, 32'h0);
        osc_wait(8 * TICK);
        check(irq === 1'b0, "R9 no irq while disabled", irq, 0);
        bus_rd(4'h8, d);
        check(d == 0, "R9 count held at zero while disabled", d, 0);
    endtask

    task automatic t_first_and_bite;
        int t0, t1, t2, p;
        logic [31:0] d;
        do_reset();
        p = TICK * 3;
        start_wdt(2, t0);
        wait_irq(4 * p, t1);
        check(t1 - t0 >= p && t1 - t0 <= p + SLACK, "R4 first overflow timing", t1 - t0, p);
        osc_wait(4);
        bus_rd(4'hC, d);
        check(d == 1, "R6 pending interrupt readable", d, 1);
        wait_bite(4 * p, t2);
        check(t2 - t1 == p, "R5 bite one period after irq", t2 - t1, p);
        check(irq === 1'b1, "R4 irq held through second window", irq, 1);
        bus_wr(4'hC, 32'h1);
        osc_wait(20);
        check(rst_req === 1'b1, "R5 rst_req sticky after service", rst_req, 1);
        check(irq === 1'b1, "R5 irq held with rst_req", irq, 1);
    endtask

    task automatic t_service;
        int t0, t1, t2, p;
        logic [31:0] d;
        do_reset();
        p = TICK * 2;
        start_wdt(1, t0);
        wait_irq(4 * p, t1);
        check(t1 - t0 >= p && t1 - t0 <= p + SLACK, "R4 overflow timing setting 1", t1 - t0, p);
        bus_wr(4'hC, 32'hFFFF_FFFE);
        osc_wait(10);
        check(irq === 1'b1, "R6 bit0-clear service ignored", irq, 1);
        bus_wr(4'hC, 32'h1);
        t0 = osc_cnt;
        osc_wait(8);
        check(irq === 1'b0, "R6 service clears irq", irq, 0);
        bus_rd(4'hC, d);
        check(d == 0, "R6 pending bit cleared", d, 0);
        wait_irq(4 * p, t2);
        check(t2 - t0 >= p && t2 - t0 <= p + SLACK, "R6 window restarts at service", t2 - t0, p);
        check(rst_req === 1'b0, "R6 no bite after service", rst_req, 0);
    endtask

    task automatic t_init;
        int t0, t1, t2, t3, p;
        do_reset();
        p = TICK * 4;
        start_wdt(3, t0);
        wait_until(t0 + 24);
        bus_wr(4'h8, 32'h5);
        wait_irq(4 * p, t1);
        check(t1 - t0 >= p && t1 - t0 <= p + SLACK, "R7 nonzero counter write ignored", t1 - t0, p);
        wait_until(t1 + 30);
        bus_wr(4'h8, 32'h0);
        t2 = osc_cnt;
        osc_wait(10);
        check(irq === 1'b1, "R7 counter init keeps irq", irq, 1);
        wait_bite(4 * p, t3);
        check(t3 - t2 >= p && t3 - t2 <= p + SLACK, "R7 counter init restarts window", t3 - t2, p);
    endtask

    task automatic t_count;
        int t0, t1;
        logic [31:0] d;
        do_reset();
        start_wdt(3, t0);
        wait_irq(16 * TICK, t1);
        wait_until(t1 + 2 * TICK + 8);
        bus_rd(4'h8, d);
        check(d == 2, "R8 count after two ticks", d, 2);
        wait_until(t1 + 3 * TICK + 8);
        bus_rd(4'h8, d);
        check(d == 3, "R8 count after three ticks", d, 3);
    endtask

    initial begin
        #900000;
        bad++; total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_regs();
        t_disabled();
        t_first_and_bite();
        t_service();
        t_init();
        t_count();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule